// File: doc/BRIEF.md
# Converter Auto-Start Source Selector

This block picks one of several peripheral flag levels to start a converter automatically. A small control register holds a source-select field. A multiplexer routes the chosen flag to an edge detector. When automatic starting is enabled and the converter is idle, a rising edge on the routed level produces a one-clock start pulse.

Edge detection sits after the multiplexer. Rewriting the select field from a source that is low to a source that is high therefore counts as a rising edge and starts a conversion. The stored copy of the routed level is refreshed on every clock, even while automatic starting is off, so turning the feature on never fires on an old edge. A start request that arrives while the converter reports busy is dropped and is not remembered.

Top module: `trig_src_sel`

## Requirements
- R1: After synchronous reset, the select field is 0, the read-back word is 0 and the start output is 0.
- R2: A register write stores write-data bits [2:0] as the select field. The read-back word shows the field in bits [2:0] one clock after the write, and bits [7:3] always read 0 whatever was written.
- R3: With auto-start enabled and busy low, a 0-to-1 change of the selected flag gives a start pulse exactly one clock later, lasting one clock.
- R4: Flags other than the selected one have no effect on the start output.
- R5: A selected flag that stays high gives only one pulse, and a 1-to-0 change gives none.
- R6: While the auto-start enable is 0, no start pulse occurs.
- R7: A flag that rose while auto-start was disabled does not give a pulse when auto-start is later enabled.
- R8: Rewriting the select field from a low source to a high source gives one start pulse on the clock after the write edge. A high-to-low switch gives none.
- R9: An edge that arrives while busy is high is ignored, and no pulse follows when busy later falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flags_i | input | 8 | Candidate start-source levels |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_wdata_i | input | 8 | Control register write data, select in [2:0] |
| cfg_rdata_o | output | 8 | Control register read-back, reserved bits 0 |
| auto_en_i | input | 1 | Auto-start enable |
| busy_i | input | 1 | Converter busy, blocks new starts |
| start_o | output | 1 | One-clock start-conversion pulse |

## Verification
The hardest cases to reach are the ones where the routed level rises without any flag moving, and the stale edge left over from a disabled period. For the first, the bench holds a new source high and the old one low, then rewrites only the select field. It checks that the pulse shows up on the second edge after the write strobe. For the stale edge, the bench raises the flag with the enable low, waits, and then enables. It counts pulses over a window to show that nothing fires.

// File: rtl/trig_src_pkg.sv
package trig_src_pkg;
  localparam int unsigned NUM_SRC = 8;
  localparam int unsigned SEL_W   = $clog2(NUM_SRC);
  localparam int unsigned REG_W   = 8;

  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/trig_cfg_reg.sv
module trig_cfg_reg
  import trig_src_pkg::*;
#(
  parameter int unsigned REG_WIDTH = REG_W,
  parameter int unsigned FIELD_W   = SEL_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [REG_WIDTH-1:0] wdata,
  output logic [FIELD_W-1:0]   sel,
  output logic [REG_WIDTH-1:0] rdata
);
  logic [FIELD_W-1:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (we) sel_q <= wdata[FIELD_W-1:0];
  end

  assign sel = sel_q;

  for (genvar b = 0; b < REG_WIDTH; b++) begin : g_rd
    if (b < FIELD_W) begin : g_fld
      assign rdata[b] = sel_q[b];
    end else begin : g_rsv
      assign rdata[b] = 1'b0;
    end
  end
endmodule

// File: rtl/trig_mux_edge.sv
module trig_mux_edge
  import trig_src_pkg::*;
#(
  parameter int unsigned N     = NUM_SRC,
  parameter int unsigned SW    = SEL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  levels,
  input  logic [SW-1:0] sel,
  output logic          rise
);
  logic routed;
  logic routed_q;

  assign routed = levels[sel];

  // refreshed every clock regardless of enable
  always_ff @(posedge clk) begin
    if (rst) routed_q <= 1'b0;
    else     routed_q <= routed;
  end

  assign rise = routed & ~routed_q;
endmodule

// File: rtl/trig_start_gate.sv
module trig_start_gate (
  input  logic clk,
  input  logic rst,
  input  logic rise,
  input  logic enable,
  input  logic busy,
  output logic start
);
  logic start_q;

  always_ff @(posedge clk) begin
    if (rst) start_q <= 1'b0;
    else     start_q <= rise & enable & ~busy;
  end

  assign start = start_q;
endmodule

// File: rtl/trig_src_sel.sv
module trig_src_sel
  import trig_src_pkg::*;
#(
  parameter int unsigned N_SRC = NUM_SRC,
  parameter int unsigned RW    = REG_W,
  localparam int unsigned SW   = $clog2(N_SRC)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N_SRC-1:0] flags_i,
  input  logic          cfg_we_i,
  input  logic [RW-1:0] cfg_wdata_i,
  output logic [RW-1:0] cfg_rdata_o,
  input  logic          auto_en_i,
  input  logic          busy_i,
  output logic          start_o
);
  logic [SW-1:0] sel;
  logic          rise;

  trig_cfg_reg #(.REG_WIDTH(RW), .FIELD_W(SW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we_i), .wdata(cfg_wdata_i),
    .sel(sel), .rdata(cfg_rdata_o)
  );

  trig_mux_edge #(.N(N_SRC), .SW(SW)) u_edge (
    .clk(clk), .rst(rst), .levels(flags_i), .sel(sel), .rise(rise)
  );

  trig_start_gate u_gate (
    .clk(clk), .rst(rst), .rise(rise), .enable(auto_en_i),
    .busy(busy_i), .start(start_o)
  );
endmodule

// File: rtl/trig_src_sel_chk.sv
module trig_src_sel_chk #(
  parameter int unsigned RW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_we_i,
  input logic [RW-1:0] cfg_wdata_i,
  input logic [RW-1:0] cfg_rdata_o,
  input logic          auto_en_i,
  input logic          busy_i,
  input logic          start_o
);
  // R2
  readback_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we_i |=> (cfg_rdata_o[2:0] == $past(cfg_wdata_i[2:0])));

  // R5
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !auto_en_i |=> !start_o);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> !start_o);

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!start_o && cfg_rdata_o == '0));
endmodule

bind trig_src_sel trig_src_sel_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst(rst), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
  .cfg_rdata_o(cfg_rdata_o), .auto_en_i(auto_en_i), .busy_i(busy_i),
  .start_o(start_o)
);

// File: tb/tb_trig_src_sel.sv
module tb_trig_src_sel;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst;
  logic [7:0] flags;
  logic       we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       en;
  logic       busy;
  logic       start;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_src_sel dut (
    .clk(clk), .rst(rst), .flags_i(flags), .cfg_we_i(we),
    .cfg_wdata_i(wdata), .cfg_rdata_o(rdata), .auto_en_i(en),
    .busy_i(busy), .start_o(start)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic [7:0] v);
    we = 1; wdata = v;
    step();
    we = 0; wdata = '0;
  endtask

  task automatic count_pulses(input int n, output int cnt);
    cnt = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (start) cnt++;
    end
  endtask

  task automatic settle();
    flags = '0; en = 0; busy = 0;
    step(); step();
  endtask

  task automatic t_reset();
    chk("R1 sel/readback", rdata, 0);
    chk("R1 start", start, 0);
  endtask

  task automatic t_readback();
    write_sel(8'hFD);
    chk("R2 readback reserved zero", rdata, 8'h05);
    write_sel(8'h02);
    chk("R2 readback field", rdata, 8'h02);
  endtask

  task automatic t_basic();
    int c;
    settle();
    write_sel(8'd2);
    en = 1; step();
    flags[2] = 1;
    chk("R3 no pulse before edge", start, 0);
    step();
    chk("R3 pulse after rise", start, 1);
    step();
    chk("R5 pulse one cycle", start, 0);
    count_pulses(4, c);
    chk("R5 held high no repeat", c, 0);
    flags[2] = 0;
    count_pulses(3, c);
    chk("R5 falling edge no pulse", c, 0);
  endtask

  task automatic t_other();
    int c;
    settle();
    write_sel(8'd3);
    en = 1; step();
    for (int k = 0; k < 8; k++) begin
      if (k != 3) begin
        flags[k] = 1; step(); step(); flags[k] = 0;
      end
    end
    count_pulses(3, c);
    chk("R4 unselected flags ignored", c, 0);
    flags[3] = 1; step();
    chk("R3 selected source 3 pulses", start, 1);
  endtask

  task automatic t_disabled();
    int c;
    settle();
    write_sel(8'd6);
    flags[6] = 1;
    count_pulses(4, c);
    chk("R6 disabled no pulse", c, 0);
    en = 1;
    count_pulses(4, c);
    chk("R7 stale edge no pulse on enable", c, 0);
  endtask

  task automatic t_switch();
    int c;
    settle();
    write_sel(8'd0);
    flags[5] = 1;
    en = 1;
    count_pulses(3, c);
    chk("R8 no pulse before switch", c, 0);
    write_sel(8'd5);
    chk("R8 no pulse at write edge", start, 0);
    step();
    chk("R8 pulse after low->high switch", start, 1);
    step();
    write_sel(8'd0);
    count_pulses(3, c);
    chk("R8 high->low switch no pulse", c, 0);
  endtask

  task automatic t_busy();
    int c;
    settle();
    write_sel(8'd1);
    en = 1; busy = 1; step();
    flags[1] = 1;
    count_pulses(3, c);
    chk("R9 busy blocks edge", c, 0);
    busy = 0;
    count_pulses(4, c);
    chk("R9 edge not queued", c, 0);
    flags[1] = 0; step();
    flags[1] = 1; step();
    chk("R9 later edge fires", start, 1);
  endtask

  initial begin
    rst = 1; flags = '0; we = 0; wdata = '0; en = 0; busy = 0;
    step(); step();
    rst = 0;
    t_reset();
    t_readback();
    t_basic();
    t_other();
    t_disabled();
    t_switch();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule